// File: doc/BRIEF.md
# Bounded Global Compressed Eviction Scanner

This block decides which slots of a shared, decoupled data array of compressed lines are given up when a new line must be placed. Every slot keeps a valid flag, a two-bit use counter and the compressed byte count of the line it holds. Hits raise a slot's counter. A fill request names how many bytes the incoming line needs. The block then walks a window of consecutive slots that starts at a rotating pointer and wraps at the end of the array. It frees slots from that window until the bytes freed cover the request.

Inside the window, an empty slot is taken first, and a line-sized hole ends the search at once. With no empty slot, the block gives up the line whose use count per stored byte is lowest. It repeats this over the same window until enough bytes are free. Each freed index leaves on a valid/ready stream. A one-cycle done pulse closes the request. A separate install port writes a new line's size into a slot. Tag bookkeeping and data movement stay with the caller.

Top module: `gce_scanner`

## Requirements
- R1: After reset no slot is valid, the scan pointer is slot 0, `ev_valid` and `done` are low, and `req_ready` and `inst_ready` are high.
- R2: An install handshake (`inst_valid` and `inst_ready`) marks slot `inst_idx` valid with size `inst_size` and counter 0. `inst_ready` is low from the cycle a request is accepted until `done` has pulsed.
- R3: A hit on a valid slot while idle raises its 2-bit counter by one. The counter saturates at 3 and never wraps to 0.
- R4: A request examines at most WIN slots, starting at the pointer in ascending index order and wrapping from NSLOTS-1 to 0.
- R5: In the first pass, the first invalid slot met is reported as the only freed slot, because it offers a full line of LINE_BYTES. The pointer then moves to the slot after it.
- R6: Among valid slots, the one with the smallest counter/size is chosen, compared as counter_a*size_b < counter_b*size_a. On a tie, the slot met earliest in the scan wins.
- R7: After each eviction the freed byte total grows by the evicted size. Passes over the same window repeat, skipping slots already freed, until the total reaches `req_bytes`. After a full first pass the pointer moves WIN slots on.
- R8: `ev_idx` stays stable while `ev_valid` is high and `ev_ready` is low. The slot is released only at the handshake.
- R9: `done` is high for exactly one cycle after the last eviction handshake. `req_ready` is low from acceptance until after `done`.
- R10: Hits that arrive while a request is in progress do not change any counter until `done`. In the `done` cycle, every slot that was hit and is still valid gains one count; several hits to one slot count once.
- R11: `done` rises k+2 cycles after acceptance when the first-pass invalid slot sits at offset k. With r evictions from valid slots it rises r*(WIN+1) cycles after acceptance, plus one cycle for each cycle an eviction waits on `ev_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_valid | input | 1 | Install request for one slot |
| inst_ready | output | 1 | High when idle; install accepted |
| inst_idx | input | IW | Slot to install |
| inst_size | input | SZW | Compressed byte count of installed line |
| hit_valid | input | 1 | Access hit to a slot |
| hit_idx | input | IW | Slot that was hit |
| req_valid | input | 1 | Fill request |
| req_ready | output | 1 | High when idle |
| req_bytes | input | SZW | Bytes the incoming line needs (1..LINE_BYTES) |
| ev_valid | output | 1 | A freed slot index is presented |
| ev_ready | input | 1 | Consumer takes the freed index |
| ev_idx | output | IW | Freed slot index |
| done | output | 1 | One-cycle end-of-request strobe |

## Verification
All timing is counted from the clock edge that accepts a request. An empty slot at window offset k raises `done` k+2 edges later. Each eviction from a valid slot costs a pass of WIN edges plus one output edge, and every edge `ev_ready` is held low adds one more. The bench drives its inputs on falling edges and samples the outputs on falling edges. It counts rising edges after acceptance until `done` appears, and compares that count with the sum above. Each freed index is recorded on the falling edge before its handshake edge. Deferred hits are placed on fixed edges inside the pass, so their effect shows in the order of evictions later.

// File: rtl/gce_pkg.sv
package gce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_EMIT,
    ST_FIN
  } gce_state_e;
endpackage

// File: rtl/gce_slot_store.sv
module gce_slot_store #(
  parameter int NSLOTS = 128,
  parameter int FW     = 2,
  parameter int SZW    = 7,
  localparam int IW    = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_fire,
  input  logic [IW-1:0]     inst_idx,
  input  logic [SZW-1:0]    inst_size,
  input  logic              hit_valid,
  input  logic [IW-1:0]     hit_idx,
  input  logic              busy,
  input  logic              apply,
  input  logic              kill,
  input  logic [IW-1:0]     kill_idx,
  input  logic [IW-1:0]     rd_idx,
  output logic              rd_valid,
  output logic [FW-1:0]     rd_freq,
  output logic [SZW-1:0]    rd_size,
  output logic [NSLOTS-1:0] valid_vec
);
  logic [NSLOTS-1:0] valid_q;
  logic [NSLOTS-1:0] pend_q;
  logic [FW-1:0]     freq_q [NSLOTS];
  logic [SZW-1:0]    size_q [NSLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      pend_q  <= '0;
      for (int i = 0; i < NSLOTS; i++) begin
        freq_q[i] <= '0;
        size_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSLOTS; i++) begin
        logic hit_here;
        logic inc;
        hit_here = hit_valid && (hit_idx == IW'(i));
        inc = valid_q[i] && (apply ? (pend_q[i] || hit_here) : (!busy && hit_here));
        if (inst_fire && inst_idx == IW'(i)) begin
          valid_q[i] <= 1'b1;
          freq_q[i]  <= '0;
          size_q[i]  <= inst_size;
        end else if (kill && kill_idx == IW'(i)) begin
          valid_q[i] <= 1'b0;
        end else if (inc && freq_q[i] != '1) begin
          freq_q[i] <= freq_q[i] + FW'(1);
        end
        if (apply)
          pend_q[i] <= 1'b0;
        else if (busy && hit_here)
          pend_q[i] <= 1'b1;
      end
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_freq   = freq_q[rd_idx];
  assign rd_size   = size_q[rd_idx];
  assign valid_vec = valid_q;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_sat
    // R3
    freq_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_q[i] == '1 && !(inst_fire && inst_idx == IW'(i))) |=> freq_q[i] == '1);
  end

  // R10
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> pend_q == '0);

  // R2
  inst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_fire |=> valid_q[$past(inst_idx)]);
endmodule

// File: rtl/gce_min_track.sv
module gce_min_track #(
  parameter int IW  = 7,
  parameter int FW  = 2,
  parameter int SZW = 7,
  localparam int PW = FW + SZW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  logic [IW-1:0]  c_idx,
  input  logic [FW-1:0]  c_freq,
  input  logic [SZW-1:0] c_size,
  output logic           n_found,
  output logic [IW-1:0]  n_idx,
  output logic [SZW-1:0] n_size
);
  logic           found_q;
  logic [IW-1:0]  bi_q;
  logic [FW-1:0]  bf_q;
  logic [SZW-1:0] bs_q;
  logic [PW-1:0]  lhs, rhs;
  logic           take;

  // cross products replace the division: cand_f/cand_s < best_f/best_s
  assign lhs  = PW'(c_freq) * PW'(bs_q);
  assign rhs  = PW'(bf_q) * PW'(c_size);
  assign take = en && (!found_q || (lhs < rhs));

  assign n_found = found_q || en;
  assign n_idx   = take ? c_idx  : bi_q;
  assign n_size  = take ? c_size : bs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      bi_q    <= '0;
      bf_q    <= '0;
      bs_q    <= '0;
    end else if (clr) begin
      found_q <= 1'b0;
    end else begin
      found_q <= n_found;
      if (take) begin
        bi_q <= c_idx;
        bf_q <= c_freq;
        bs_q <= c_size;
      end
    end
  end

  // R6
  keep_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (found_q && en && !clr && !(lhs < rhs)) |=> bi_q == $past(bi_q));
endmodule

// File: rtl/gce_ctrl.sv
module gce_ctrl
  import gce_pkg::*;
#(
  parameter int NSLOTS     = 128,
  parameter int WIN        = 64,
  parameter int SZW        = 7,
  parameter int LINE_BYTES = 64,
  localparam int IW  = $clog2(NSLOTS),
  localparam int OW  = $clog2(WIN),
  localparam int FDW = SZW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SZW-1:0]    req_bytes,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [IW-1:0]     ev_idx,
  output logic              done,
  output logic [IW-1:0]     rd_idx,
  input  logic              rd_valid,
  input  logic [NSLOTS-1:0] valid_vec,
  output logic              mt_clr,
  output logic              mt_en,
  input  logic              mt_found,
  input  logic [IW-1:0]     mt_idx,
  input  logic [SZW-1:0]    mt_size,
  output logic              kill,
  output logic [IW-1:0]     kill_idx,
  output logic              busy,
  output logic              apply
);
  gce_state_e     st;
  logic [IW-1:0]  ptr_q, base_q, sel_idx_q;
  logic [OW-1:0]  off_q;
  logic           r0_q, sel_free_q;
  logic [SZW-1:0] need_q;
  logic [FDW-1:0] freed_q, sel_amt_q, freed_nx;
  logic [IW-1:0]  cur;
  logic           first_free, last;

  function automatic logic [IW-1:0] wrap(input logic [IW:0] x);
    return (x >= (IW+1)'(NSLOTS)) ? IW'(x - (IW+1)'(NSLOTS)) : IW'(x);
  endfunction

  assign cur        = wrap((IW+1)'(base_q) + (IW+1)'(off_q));
  assign rd_idx     = cur;
  assign first_free = (st == ST_WALK) && r0_q && !rd_valid;
  assign last       = off_q == OW'(WIN - 1);
  assign mt_en      = (st == ST_WALK) && rd_valid;
  assign mt_clr     = (st == ST_IDLE) || first_free || ((st == ST_WALK) && last);
  assign freed_nx   = freed_q + sel_amt_q;

  assign req_ready = st == ST_IDLE;
  assign ev_valid  = st == ST_EMIT;
  assign ev_idx    = sel_idx_q;
  assign done      = st == ST_FIN;
  assign kill      = (st == ST_EMIT) && ev_ready;
  assign kill_idx  = sel_idx_q;
  assign busy      = st != ST_IDLE;
  assign apply     = st == ST_FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ptr_q      <= '0;
      base_q     <= '0;
      off_q      <= '0;
      r0_q       <= 1'b0;
      need_q     <= '0;
      freed_q    <= '0;
      sel_idx_q  <= '0;
      sel_amt_q  <= '0;
      sel_free_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          base_q  <= ptr_q;
          off_q   <= '0;
          r0_q    <= 1'b1;
          need_q  <= req_bytes;
          freed_q <= '0;
          st      <= ST_WALK;
        end
        ST_WALK: begin
          if (first_free) begin
            sel_idx_q  <= cur;
            sel_amt_q  <= FDW'(LINE_BYTES);
            sel_free_q <= 1'b1;
            ptr_q      <= wrap((IW+1)'(cur) + (IW+1)'(1));
            st         <= ST_EMIT;
          end else if (last) begin
            if (r0_q) ptr_q <= wrap((IW+1)'(base_q) + (IW+1)'(WIN));
            r0_q  <= 1'b0;
            off_q <= '0;
            if (mt_found) begin
              sel_idx_q  <= mt_idx;
              sel_amt_q  <= FDW'(mt_size);
              sel_free_q <= 1'b0;
              st         <= ST_EMIT;
            end else begin
              st <= ST_FIN;
            end
          end else begin
            off_q <= off_q + OW'(1);
          end
        end
        ST_EMIT: if (ev_ready) begin
          freed_q <= freed_nx;
          off_q   <= '0;
          st      <= (freed_nx >= FDW'(need_q)) ? ST_FIN : ST_WALK;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_idx)));

  // R9
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  ev_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !sel_free_q) |-> valid_vec[ev_idx]);

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NSLOTS);
endmodule

// File: rtl/gce_scanner.sv
module gce_scanner #(
  parameter int NSLOTS     = 128,
  parameter int WIN        = 64,
  parameter int FW         = 2,
  parameter int SZW        = 7,
  parameter int LINE_BYTES = 64,
  localparam int IW = $clog2(NSLOTS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inst_valid,
  output logic           inst_ready,
  input  logic [IW-1:0]  inst_idx,
  input  logic [SZW-1:0] inst_size,
  input  logic           hit_valid,
  input  logic [IW-1:0]  hit_idx,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [SZW-1:0] req_bytes,
  output logic           ev_valid,
  input  logic           ev_ready,
  output logic [IW-1:0]  ev_idx,
  output logic           done
);
  logic              busy, apply, kill, inst_fire;
  logic [IW-1:0]     kill_idx, rd_idx, mt_idx;
  logic              rd_valid, mt_clr, mt_en, mt_found;
  logic [FW-1:0]     rd_freq;
  logic [SZW-1:0]    rd_size, mt_size;
  logic [NSLOTS-1:0] valid_vec;

  assign inst_ready = !busy;
  assign inst_fire  = inst_valid && !busy;

  gce_slot_store #(.NSLOTS(NSLOTS), .FW(FW), .SZW(SZW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .inst_fire(inst_fire), .inst_idx(inst_idx), .inst_size(inst_size),
    .hit_valid(hit_valid), .hit_idx(hit_idx),
    .busy(busy), .apply(apply), .kill(kill), .kill_idx(kill_idx),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_freq(rd_freq), .rd_size(rd_size),
    .valid_vec(valid_vec)
  );

  gce_min_track #(.IW(IW), .FW(FW), .SZW(SZW)) u_min (
    .clk(clk), .rst_n(rst_n), .clr(mt_clr), .en(mt_en),
    .c_idx(rd_idx), .c_freq(rd_freq), .c_size(rd_size),
    .n_found(mt_found), .n_idx(mt_idx), .n_size(mt_size)
  );

  gce_ctrl #(.NSLOTS(NSLOTS), .WIN(WIN), .SZW(SZW), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_bytes(req_bytes),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_idx(ev_idx), .done(done),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .valid_vec(valid_vec),
    .mt_clr(mt_clr), .mt_en(mt_en), .mt_found(mt_found), .mt_idx(mt_idx), .mt_size(mt_size),
    .kill(kill), .kill_idx(kill_idx), .busy(busy), .apply(apply)
  );
endmodule

// File: tb/sim_gce_scanner.sv
`timescale 1ns/1ps
module sim_gce_scanner;
  localparam int NSLOTS = 128;
  localparam int WIN    = 64;
  localparam int IW     = 7;
  localparam int SZW    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inst_valid = 1'b0, hit_valid = 1'b0, req_valid = 1'b0, ev_ready = 1'b1;
  logic [IW-1:0] inst_idx = '0, hit_idx = '0;
  logic [SZW-1:0] inst_size = '0, req_bytes = '0;
  logic inst_ready, req_ready, ev_valid, done;
  logic [IW-1:0] ev_idx;

  int errors = 0, checks = 0;
  int got [0:127];
  int got_n, lat;
  bit hung = 1'b0;
  bit inject = 1'b0;

  always #2.5 clk = ~clk;

  gce_scanner u0 (
    .clk(clk), .rst_n(rst_n),
    .inst_valid(inst_valid), .inst_ready(inst_ready), .inst_idx(inst_idx), .inst_size(inst_size),
    .hit_valid(hit_valid), .hit_idx(hit_idx),
    .req_valid(req_valid), .req_ready(req_ready), .req_bytes(req_bytes),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_idx(ev_idx), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic install(input int idx, input int size);
    inst_valid = 1'b1; inst_idx = IW'(idx); inst_size = SZW'(size);
    @(negedge clk);
    inst_valid = 1'b0;
  endtask

  task automatic hit(input int idx, input int times);
    for (int t = 0; t < times; t++) begin
      hit_valid = 1'b1; hit_idx = IW'(idx);
      @(negedge clk);
    end
    hit_valid = 1'b0;
  endtask

  // issue one request; lat = rising edges from acceptance to done
  task automatic run_req(input int bytes, input int stall);
    int stall_left;
    int held;
    bit seen;
    stall_left = stall; seen = 1'b0; held = 0;
    ev_ready = (stall == 0);
    req_valid = 1'b1; req_bytes = SZW'(bytes);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; got_n = 0;
    while (!done && lat < 20000) begin
      if (ev_valid) begin
        if (!seen) begin held = int'(ev_idx); seen = 1'b1; end
        if (stall_left > 0) begin
          stall_left--;
          // R8: index stays put while the consumer stalls
          chk(int'(ev_idx) == held, "R8 stalled index", int'(ev_idx), held);
        end else begin
          ev_ready = 1'b1;
          if (got_n < 128) got[got_n] = int'(ev_idx);
          got_n++;
        end
      end
      if (inject) begin
        hit_valid = 1'b0;
        if (lat == 3) begin hit_valid = 1'b1; hit_idx = IW'(67); end
        if (lat == 4) begin hit_valid = 1'b1; hit_idx = IW'(10); end
        if (lat == 3) chk(inst_ready == 1'b0, "R2 inst_ready low while busy", int'(inst_ready), 0);
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    hit_valid = 1'b0;
    ev_ready = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(inst_ready == 1'b1, "R1 inst_ready", int'(inst_ready), 1);
    chk(ev_valid == 1'b0, "R1 ev_valid", int'(ev_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
  endtask

  // R1 R5: empty array, pointer from 0, invalid slot taken at once
  task automatic t_empty();
    run_req(10, 0);
    chk(got_n == 1 && got[0] == 0, "R5 first empty slot", got[0], 0);
    chk(lat == 2, "R11 latency empty k=0", lat, 2);
    run_req(64, 0);
    chk(got_n == 1 && got[0] == 1, "R5 pointer after empty", got[0], 1);
  endtask

  // R6 ties: all counters zero, earliest slot in window wins
  task automatic t_tie();
    for (int i = 0; i < NSLOTS; i++) install(i, 64);
    run_req(64, 0);
    chk(got_n == 1, "R6 one eviction", got_n, 1);
    chk(got[0] == 2, "R6 tie earliest", got[0], 2);
    chk(lat == WIN + 1, "R11 latency one pass", lat, WIN + 1);
  endtask

  // R3 R4 R6 R7: wrap, ratio order, saturation
  task automatic t_ratio();
    for (int i = 66; i < 130; i++) begin install(i % NSLOTS, 1); hit(i % NSLOTS, 3); end
    hit(127, 1);               // R3: fourth hit must stay at 3
    install(70, 16); hit(70, 1);
    install(0, 32);  hit(0, 1);
    install(1, 64);  hit(1, 2);
    run_req(40, 0);
    chk(got_n == 2, "R7 two evictions", got_n, 2);
    chk(got[0] == 0, "R6 R4 wrapped minimum first", got[0], 0);
    chk(got[1] == 1, "R7 second pass skips freed", got[1], 1);
    chk(lat == 2 * (WIN + 1), "R11 latency two passes", lat, 2 * (WIN + 1));
  endtask

  // R7 worst case: 64 one-byte lines for one full line
  task automatic t_worst();
    int bad;
    bad = 0;
    for (int i = 2; i < 66; i++) install(i, 1);
    run_req(64, 0);
    chk(got_n == 64, "R7 count of one-byte evictions", got_n, 64);
    for (int j = 0; j < 64 && j < got_n; j++) if (got[j] != 2 + j) bad++;
    chk(bad == 0, "R7 eviction order", bad, 0);
    chk(lat == 64 * (WIN + 1), "R11 latency worst case", lat, 64 * (WIN + 1));
  endtask

  // R10: hits during a scan are held, then applied at done
  task automatic t_held();
    for (int i = 66; i < 130; i++) install(i % NSLOTS, 8);
    for (int i = 2; i < 66; i++) begin install(i, 8); if (i != 10) hit(i, 1); end
    inject = 1'b1;
    run_req(16, 0);
    inject = 1'b0;
    chk(got_n == 2 && got[0] == 66, "R10 first eviction", got[0], 66);
    chk(got[1] == 67, "R10 hit held during scan", got[1], 67);
    // window 2..65 all count 1 now if slot 10 got its held hit
    run_req(8, 5);
    chk(got_n == 1 && got[0] == 2, "R10 held hit applied", got[0], 2);
    chk(lat == WIN + 1 + 5, "R11 latency with stall", lat, WIN + 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_tie();
    t_ratio();
    t_worst();
    t_held();
    if (!hung) begin
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    hung = 1'b1;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule